// File: doc/BRIEF.md
# Bus Address Breakpoint Controller

This block sits beside a processor core and watches every bus cycle. Each of its two channels holds a compare address, a per-bit ignore mask, a choice of which kind of cycle counts, and a choice of which bus masters count. When a bus cycle satisfies a channel, the channel sets its sticky match flag. The block then asks the core for a break exception.

The break timing depends on the kind of cycle that matched. A matching instruction fetch is remembered under the prefetch tag carried with the fetch. The break is raised only when the core announces that this tagged instruction is about to execute. A pipeline flush discards any remembered fetch matches. A matching data access is held and released at the next instruction-completion strobe, so the break lands after the accessing instruction has finished.

A module-stop input parks the whole block. While it is high, no cycle matches, pending breaks are dropped, register writes are ignored and reads return zero. The configuration is kept.

Top module: `addr_break_ctrl`

## Requirements
- R1: While `mod_stop` is high, register writes have no effect, `reg_rdata` reads 0, no flag is set and `brk_req` stays low; held state is kept. After reset every register reads 0 and `brk_req` is 0.
- R2: The register address is {channel, field}. The channel is the upper bit (0 = A, 1 = B). Field 0 is the 24-bit compare address, field 1 is the 24-bit mask and field 2 is control. Control bits: bit 0 enable, bits 2:1 cycle kind, bit 3 include-DMA, bit 4 match flag. Field 3 reads 0. Written values read back.
- R3: An address matches when every bit whose mask bit is 0 equals the compare bit. Bits whose mask bit is 1 are ignored.
- R4: Cycle kind 0 matches only fetches, 1 only data reads, 2 only data writes, and 3 any data read or write.
- R5: With include-DMA at 0, only CPU cycles (`bus_from_dma` = 0) match. With include-DMA at 1, both CPU and DMA cycles match.
- R6: A fetch match raises no request on its own. One cycle after an `exec_start` whose `exec_tag` equals the fetch's `bus_tag`, `brk_req` and `brk_pre` are high for one cycle. A different tag raises nothing.
- R7: `pipe_flush` drops every remembered fetch match. A later non-matching fetch under the same tag also drops it.
- R8: A data match raises no request on its own. One cycle after the next `instr_done` strobe, `brk_req` and `brk_post` are high for one cycle, with `brk_pre` low.
- R9: The flag is set by a match and stays set. Writing control with bit 4 = 0 clears it, writing bit 4 = 1 leaves it unchanged, and a match in the same cycle as a clearing write wins.
- R10: A channel whose enable bit is 0 never sets its flag and never causes a request.
- R11: When both channels match the same cycle, both flags are set and exactly one one-cycle request results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_stop | input | 1 | Module stop: parks the block |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | {channel, field} register select |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data (combinational) |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 24 | Bus cycle address |
| bus_is_fetch | input | 1 | Cycle is an instruction fetch |
| bus_is_write | input | 1 | Data cycle is a write |
| bus_from_dma | input | 1 | Cycle issued by the DMA/transfer controller |
| bus_tag | input | 2 | Prefetch tag of a fetch cycle |
| exec_start | input | 1 | Core is about to execute a tagged instruction |
| exec_tag | input | 2 | Tag of that instruction |
| pipe_flush | input | 1 | Prefetched instructions discarded |
| instr_done | input | 1 | An instruction finished executing |
| brk_req | output | 1 | Break request to the core |
| brk_pre | output | 1 | Request is a before-execute (fetch) break |
| brk_post | output | 1 | Request is an after-completion (data) break |

## Verification
A flag is set at the clock edge that samples the matching cycle, so the bench reads it through the register port on the falling edge after that edge. Requests are registered one edge after the `exec_start` or `instr_done` strobe. The bench raises a strobe for one cycle and samples `brk_req`, `brk_pre` and `brk_post` at the falling edge right after it. It also samples once before the strobe, to show that a match alone raises nothing, and once after it, to show that the pulse is a single cycle. All inputs change on falling edges, and register reads settle 1 ns after the address is set.

// File: rtl/abc_pkg.sv
package abc_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_RDWR  = 2'd3
  } cyc_kind_e;

  localparam logic [1:0] FLD_CMP = 2'd0;
  localparam logic [1:0] FLD_MSK = 2'd1;
  localparam logic [1:0] FLD_CTL = 2'd2;

  localparam int CTL_EN   = 0;
  localparam int CTL_KIND = 1;
  localparam int CTL_DMA  = 3;
  localparam int CTL_FLAG = 4;

  function automatic logic addr_hits(input logic [23:0] a, input logic [23:0] c,
                                     input logic [23:0] m);
    return ((a ^ c) & ~m) == '0;
  endfunction

  function automatic logic kind_ok(input cyc_kind_e k, input logic is_fetch,
                                   input logic is_write);
    case (k)
      KIND_FETCH: return is_fetch;
      KIND_READ:  return !is_fetch && !is_write;
      KIND_WRITE: return !is_fetch && is_write;
      default:    return !is_fetch;
    endcase
  endfunction

  function automatic logic master_ok(input logic dma_too, input logic from_dma);
    return !from_dma || dma_too;
  endfunction

endpackage

// File: rtl/abc_channel.sv
module abc_channel
  import abc_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          wr_en,
  input  logic [1:0]    fld,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] rdata,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_is_fetch,
  input  logic          bus_is_write,
  input  logic          bus_from_dma,
  output logic          hit
);

  logic [AW-1:0] cmp_q, msk_q;
  logic          en_q, dma_q, flag_q;
  cyc_kind_e     kind_q;
  logic          ctl_wr;

  assign ctl_wr = wr_en && (fld == FLD_CTL);

  assign hit = active && en_q && bus_valid
             && addr_hits(bus_addr, cmp_q, msk_q)
             && kind_ok(kind_q, bus_is_fetch, bus_is_write)
             && master_ok(dma_q, bus_from_dma);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      msk_q  <= '0;
      en_q   <= 1'b0;
      dma_q  <= 1'b0;
      kind_q <= KIND_FETCH;
    end else if (wr_en) begin
      if (fld == FLD_CMP) cmp_q <= wdata;
      if (fld == FLD_MSK) msk_q <= wdata;
      if (fld == FLD_CTL) begin
        en_q   <= wdata[CTL_EN];
        dma_q  <= wdata[CTL_DMA];
        kind_q <= cyc_kind_e'(wdata[CTL_KIND +: 2]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            flag_q <= 1'b0;
    else if (hit)                          flag_q <= 1'b1;
    else if (ctl_wr && !wdata[CTL_FLAG])   flag_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (fld)
      FLD_CMP: rdata = cmp_q;
      FLD_MSK: rdata = msk_q;
      FLD_CTL: begin
        rdata[CTL_EN]        = en_q;
        rdata[CTL_KIND +: 2] = kind_q;
        rdata[CTL_DMA]       = dma_q;
        rdata[CTL_FLAG]      = flag_q;
      end
      default: rdata = '0;
    endcase
  end

  AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q); // R9
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !flag_q) |=> !flag_q); // R10
  AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !hit); // R10
  AST_STOPPED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !hit); // R1

endmodule

// File: rtl/abc_sequencer.sv
module abc_sequencer #(
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             any_hit,
  input  logic             bus_valid,
  input  logic             bus_is_fetch,
  input  logic [TAG_W-1:0] bus_tag,
  input  logic             exec_start,
  input  logic [TAG_W-1:0] exec_tag,
  input  logic             pipe_flush,
  input  logic             instr_done,
  output logic             brk_req,
  output logic             brk_pre,
  output logic             brk_post
);

  localparam int NTAG = 1 << TAG_W;

  logic [NTAG-1:0] fpend_q, fpend_d;
  logic            dpend_q, dpend_d;
  logic            pre_d, post_d;
  logic            fetch_hit, data_hit;

  assign fetch_hit = any_hit && bus_is_fetch;
  assign data_hit  = any_hit && !bus_is_fetch;

  always_comb begin
    fpend_d = fpend_q;
    if (exec_start) fpend_d[exec_tag] = 1'b0;
    if (bus_valid && bus_is_fetch) fpend_d[bus_tag] = fetch_hit;
    if (!active || pipe_flush) fpend_d = '0;
  end

  always_comb begin
    dpend_d = dpend_q;
    if (data_hit)        dpend_d = 1'b1;
    else if (instr_done) dpend_d = 1'b0;
    if (!active)         dpend_d = 1'b0;
  end

  assign pre_d  = active && exec_start && !pipe_flush && fpend_q[exec_tag];
  assign post_d = active && instr_done && dpend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fpend_q  <= '0;
      dpend_q  <= 1'b0;
      brk_pre  <= 1'b0;
      brk_post <= 1'b0;
      brk_req  <= 1'b0;
    end else begin
      fpend_q  <= fpend_d;
      dpend_q  <= dpend_d;
      brk_pre  <= pre_d;
      brk_post <= post_d;
      brk_req  <= pre_d || post_d;
    end
  end

  AST_PRE_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pre |-> $past(exec_start)); // R6
  AST_FLUSH_NO_FETCH_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_flush |=> !brk_pre); // R7
  AST_POST_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_post |-> $past(instr_done)); // R8
  AST_DATA_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_hit && !dpend_q) |=> !brk_post); // R8
  AST_REQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (brk_pre || brk_post)); // R11
  AST_STOP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !brk_req); // R1

endmodule

// File: rtl/addr_break_ctrl.sv
module addr_break_ctrl
  import abc_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int AW    = 24,
  parameter int TAG_W = 2,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RA_W = CH_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_stop,
  input  logic             reg_wr,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [AW-1:0]    reg_wdata,
  output logic [AW-1:0]    reg_rdata,
  input  logic             bus_valid,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_is_fetch,
  input  logic             bus_is_write,
  input  logic             bus_from_dma,
  input  logic [TAG_W-1:0] bus_tag,
  input  logic             exec_start,
  input  logic [TAG_W-1:0] exec_tag,
  input  logic             pipe_flush,
  input  logic             instr_done,
  output logic             brk_req,
  output logic             brk_pre,
  output logic             brk_post
);

  logic            active;
  logic [CH_W-1:0] reg_ch;
  logic [1:0]      reg_fld;
  logic [NCH-1:0]  ch_hit;
  logic [AW-1:0]   ch_rdata [NCH];

  assign active  = !mod_stop;
  assign reg_ch  = reg_addr[RA_W-1:2];
  assign reg_fld = reg_addr[1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    abc_channel #(.AW(AW)) i_ch (
      .clk          (clk),
      .rst_n        (rst_n),
      .active       (active),
      .wr_en        (active && reg_wr && (int'(reg_ch) == g)),
      .fld          (reg_fld),
      .wdata        (reg_wdata),
      .rdata        (ch_rdata[g]),
      .bus_valid    (bus_valid),
      .bus_addr     (bus_addr),
      .bus_is_fetch (bus_is_fetch),
      .bus_is_write (bus_is_write),
      .bus_from_dma (bus_from_dma),
      .hit          (ch_hit[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (active && int'(reg_ch) < NCH) reg_rdata = ch_rdata[reg_ch];
  end

  abc_sequencer #(.TAG_W(TAG_W)) i_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .active       (active),
    .any_hit      (|ch_hit),
    .bus_valid    (bus_valid),
    .bus_is_fetch (bus_is_fetch),
    .bus_tag      (bus_tag),
    .exec_start   (exec_start),
    .exec_tag     (exec_tag),
    .pipe_flush   (pipe_flush),
    .instr_done   (instr_done),
    .brk_req      (brk_req),
    .brk_pre      (brk_pre),
    .brk_post     (brk_post)
  );

  AST_STOPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mod_stop |-> (reg_rdata == '0)); // R1
  AST_HIT_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (ch_hit == '0)); // R3

endmodule

// File: tb/test_addr_break_ctrl.sv
module test_addr_break_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_stop = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [23:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic        bus_valid = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        bus_is_fetch = 1'b0;
  logic        bus_is_write = 1'b0;
  logic        bus_from_dma = 1'b0;
  logic [1:0]  bus_tag = '0;
  logic        exec_start = 1'b0;
  logic [1:0]  exec_tag = '0;
  logic        pipe_flush = 1'b0;
  logic        instr_done = 1'b0;
  logic        brk_req, brk_pre, brk_post;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  addr_break_ctrl i_addr_break_ctrl (.*);

  typedef struct packed {
    logic [23:0] cmp;
    logic [23:0] msk;
    logic [1:0]  kind;
    logic        dmat;
    logic [23:0] addr;
    logic        f;
    logic        w;
    logic        d;
    logic        exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{24'h123456, 24'h000000, 2'd1, 1'b0, 24'h123456, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 exact
    '{24'h123456, 24'h000000, 2'd1, 1'b0, 24'h123457, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 bit0 differs
    '{24'h123456, 24'h00000F, 2'd1, 1'b0, 24'h12345B, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 masked
    '{24'h123456, 24'h00000F, 2'd1, 1'b0, 24'h12346B, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 unmasked bit
    '{24'hFF0000, 24'h00FFFF, 2'd2, 1'b0, 24'hFFABCD, 1'b0, 1'b1, 1'b0, 1'b1}, // R4 write
    '{24'hFF0000, 24'h00FFFF, 2'd2, 1'b0, 24'hFFABCD, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 read vs write
    '{24'h00A000, 24'h000000, 2'd3, 1'b0, 24'h00A000, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 rw read
    '{24'h00A000, 24'h000000, 2'd3, 1'b0, 24'h00A000, 1'b0, 1'b1, 1'b0, 1'b1}, // R4 rw write
    '{24'h00A000, 24'h000000, 2'd3, 1'b0, 24'h00A000, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 rw fetch
    '{24'h00B000, 24'h000000, 2'd0, 1'b0, 24'h00B000, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 fetch
    '{24'h00B000, 24'h000000, 2'd0, 1'b0, 24'h00B000, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 fetch vs read
    '{24'h00C000, 24'h000000, 2'd1, 1'b0, 24'h00C000, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 dma excluded
    '{24'h00C000, 24'h000000, 2'd1, 1'b1, 24'h00C000, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 dma included
    '{24'h00C000, 24'h000000, 2'd1, 1'b1, 24'h00C000, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 cpu included
    '{24'hABCDEF, 24'hFFFFFF, 2'd1, 1'b0, 24'h000001, 1'b0, 1'b0, 1'b0, 1'b1}  // R3 full mask
  };

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [23:0] exp, input string req);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, req, "register read", 32'(reg_rdata), 32'(exp));
  endtask

  task automatic bus(input logic [23:0] a, input logic f, input logic w,
                     input logic d, input logic [1:0] t);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_is_fetch = f; bus_is_write = w;
    bus_from_dma = d; bus_tag = t;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic req_check(input logic er, input logic ep, input logic eq, input string req);
    #1;
    check(brk_req == er, req, "brk_req", 32'(brk_req), 32'(er));
    check(brk_pre == ep && brk_post == eq, req, "pre/post",
          {30'd0, brk_pre, brk_post}, {30'd0, ep, eq});
  endtask

  task automatic do_exec(input logic [1:0] t);
    @(negedge clk);
    exec_start = 1'b1; exec_tag = t;
    @(negedge clk);
    exec_start = 1'b0;
  endtask

  task automatic do_done();
    @(negedge clk);
    instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    pipe_flush = 1'b1;
    @(negedge clk);
    pipe_flush = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and stopped behaviour
    rd_check(3'd0, 24'h0, "R1");
    req_check(1'b0, 1'b0, 1'b0, "R1");
    wr(3'd0, 24'hABCDEF);
    rd_check(3'd0, 24'h0, "R1");
    mod_stop = 1'b0;
    rd_check(3'd0, 24'h0, "R1");
    rd_check(3'd2, 24'h0, "R2");
    // R2 register read back
    wr(3'd4, 24'h5A5A5A); rd_check(3'd4, 24'h5A5A5A, "R2");
    wr(3'd5, 24'h0000FF); rd_check(3'd5, 24'h0000FF, "R2");
    wr(3'd6, 24'h00000D); rd_check(3'd6, 24'h00000D, "R2");
    rd_check(3'd7, 24'h0, "R2");
    wr(3'd6, 24'h0);

    // R3 R4 R5 vector table on channel A
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, VECS[i].cmp);
      wr(3'd1, VECS[i].msk);
      wr(3'd2, {19'd0, 1'b0, VECS[i].dmat, VECS[i].kind, 1'b1});
      bus(VECS[i].addr, VECS[i].f, VECS[i].w, VECS[i].d, 2'd0);
      reg_addr = 3'd2;
      #1;
      check(reg_rdata[4] == VECS[i].exp, "R3/R4/R5", $sformatf("vector %0d flag", i),
            32'(reg_rdata[4]), 32'(VECS[i].exp));
    end
    do_flush();
    do_done();
    @(negedge clk);

    // R6 fetch break tagged to the execute announcement
    wr(3'd0, 24'h001000); wr(3'd1, 24'h0); wr(3'd2, 24'h000001);
    bus(24'h001000, 1'b1, 1'b0, 1'b0, 2'd1);
    req_check(1'b0, 1'b0, 1'b0, "R6");
    do_exec(2'd0);
    req_check(1'b0, 1'b0, 1'b0, "R6");
    do_exec(2'd1);
    req_check(1'b1, 1'b1, 1'b0, "R6");
    @(negedge clk);
    req_check(1'b0, 1'b0, 1'b0, "R6");

    // R7 flush and tag reuse drop fetch matches
    bus(24'h001000, 1'b1, 1'b0, 1'b0, 2'd2);
    do_flush();
    do_exec(2'd2);
    req_check(1'b0, 1'b0, 1'b0, "R7");
    bus(24'h001000, 1'b1, 1'b0, 1'b0, 2'd3);
    bus(24'h002000, 1'b1, 1'b0, 1'b0, 2'd3);
    do_exec(2'd3);
    req_check(1'b0, 1'b0, 1'b0, "R7");

    // R8 data break after completion
    wr(3'd0, 24'h004000); wr(3'd2, 24'h000003);
    bus(24'h004000, 1'b0, 1'b0, 1'b0, 2'd0);
    req_check(1'b0, 1'b0, 1'b0, "R8");
    do_done();
    req_check(1'b1, 1'b0, 1'b1, "R8");

    // R9 sticky flag write semantics
    rd_check(3'd2, 24'h000013, "R9");
    wr(3'd2, 24'h000013); rd_check(3'd2, 24'h000013, "R9");
    wr(3'd2, 24'h000003); rd_check(3'd2, 24'h000003, "R9");

    // R10 disabled channels stay quiet
    wr(3'd2, 24'h000002);
    wr(3'd4, 24'h004000); wr(3'd5, 24'h0); wr(3'd6, 24'h000002);
    bus(24'h004000, 1'b0, 1'b0, 1'b0, 2'd0);
    rd_check(3'd6, 24'h000002, "R10");
    rd_check(3'd2, 24'h000002, "R10");
    do_done();
    req_check(1'b0, 1'b0, 1'b0, "R10");

    // R11 both channels in one cycle
    wr(3'd2, 24'h000003); wr(3'd6, 24'h000003);
    bus(24'h004000, 1'b0, 1'b0, 1'b0, 2'd0);
    rd_check(3'd2, 24'h000013, "R11");
    rd_check(3'd6, 24'h000013, "R11");
    do_done();
    req_check(1'b1, 1'b0, 1'b1, "R11");
    @(negedge clk);
    req_check(1'b0, 1'b0, 1'b0, "R11");

    // R1 no matching while stopped, configuration kept
    wr(3'd2, 24'h000003); wr(3'd6, 24'h000003);
    @(negedge clk);
    mod_stop = 1'b1;
    rd_check(3'd2, 24'h0, "R1");
    bus(24'h004000, 1'b0, 1'b0, 1'b0, 2'd0);
    do_done();
    req_check(1'b0, 1'b0, 1'b0, "R1");
    mod_stop = 1'b0;
    rd_check(3'd2, 24'h000003, "R1");
    rd_check(3'd0, 24'h004000, "R1");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule